// File: doc/BRIEF.md
# Serial MII segment port (PHY side)

This block is the PHY-side end of one port of a serial media-independent link clocked at 125 MHz. A single receive line and a single transmit line each carry 10-bit segments. The MAC marks the start of each segment with a one-cycle sync pulse. In the receive direction the block takes a carrier flag, a data-valid flag and a byte from the port logic and shifts them out serially. When no frame data is valid, it sends a status byte instead of the data byte. In the transmit direction it gathers ten serial bits into an error flag, an enable flag and a byte, and it raises a one-cycle strobe when the fields are new.

A mode input selects between the fast and the slow line rate. At the slow rate every segment is repeated ten times in both directions. On receive, the block samples its inputs once and sends the same segment ten times. On transmit, the MAC repeats each segment ten times and the block keeps only the fifth complete copy. A sync pulse that arrives before a segment is finished restarts the bit position, so the MAC can realign the link at any cycle.

Top module: `smii_seg_port`

## Requirements
- R1: After reset `rxd_o` is 0, `tx_data_o`, `tx_en_o` and `tx_err_o` are 0, and `tx_stb_o` is low.
- R2: After a clock edge at which `sync_i` is high, `rxd_o` carries carrier sense in the next cycle, then data valid, then data bits 0 to 7, one bit per cycle.
- R3: When data valid is 1, the eight data bits of the receive segment equal `rx_data_i` as it was sampled.
- R4: When data valid is 0, the data field is a status byte: bit 0 previous-frame error, bit 1 speed (1 = fast mode, 0 = slow mode), bit 2 full duplex, bit 3 link up, bit 4 jabber, bit 5 constant 1, bit 6 false carrier, bit 7 constant 1.
- R5: On transmit, the bit on `txd_i` at the sync edge is the error flag, the next bit is the enable flag, and data bits 0 to 7 follow. The decoded fields and a one-cycle `tx_stb_o` appear in the cycle after the edge that samples the tenth bit.
- R6: In fast mode (`mode_10m_i` = 0) every complete transmit segment is decoded and strobed, and every receive sync loads fresh inputs.
- R7: In slow mode the receive inputs are sampled at the first sync after slow mode is entered and then at every tenth sync. The ten segments in between are identical, even if the inputs change.
- R8: In slow mode only the fifth complete transmit segment of each group of ten is decoded, counted from entry into slow mode. Exactly one strobe appears per ten segments.
- R9: A sync pulse before the tenth bit abandons the partial transmit segment without a strobe. The receive line restarts with the carrier bit of a newly loaded segment.
- R10: `tx_data_o`, `tx_en_o` and `tx_err_o` keep their values in every cycle in which no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_10m_i | input | 1 | 1 selects slow mode with ten-fold repetition |
| sync_i | input | 1 | Segment start pulse from the MAC |
| rx_crs_i | input | 1 | Carrier sense to send |
| rx_dv_i | input | 1 | Receive data valid |
| rx_data_i | input | 8 | Receive byte |
| rx_err_prev_i | input | 1 | Error seen in the previous frame (status) |
| link_up_i | input | 1 | Link up (status) |
| full_duplex_i | input | 1 | Full duplex (status) |
| jabber_i | input | 1 | Jabber detected (status) |
| false_carrier_i | input | 1 | False carrier detected (status) |
| rxd_o | output | 1 | Serial receive line to the MAC |
| txd_i | input | 1 | Serial transmit line from the MAC |
| tx_data_o | output | 8 | Decoded transmit byte |
| tx_en_o | output | 1 | Decoded transmit enable |
| tx_err_o | output | 1 | Decoded transmit error |
| tx_stb_o | output | 1 | One-cycle pulse when new transmit fields are presented |

## Verification
The bench builds the block with its default parameters: ten repetitions per slow-mode segment, capture of the fifth transmit copy, and an 8-bit data field. This lets one directed run cover a full slow-mode group in both directions. The bench sends a different byte in each of the ten transmit copies, so the choice of the fifth copy shows at the ports. It also changes the receive inputs after the first slow segment, so the single sampling point shows as well. A sync pulse four bits into a segment covers the realignment path.

// File: rtl/smii_seg_pkg.sv
package smii_seg_pkg;

   localparam int SEG_DATA_W = 8;
   localparam int SEG_W      = SEG_DATA_W + 2;

   // status byte bit positions (decoded by the MAC)
   localparam int ST_ERR    = 0;
   localparam int ST_SPEED  = 1;
   localparam int ST_DUPLEX = 2;
   localparam int ST_LINK   = 3;
   localparam int ST_JAB    = 4;
   localparam int ST_NIBV   = 5;
   localparam int ST_FCAR   = 6;
   localparam int ST_ONE    = 7;

   // bit 0 is sent first
   typedef struct packed {
      logic [SEG_DATA_W-1:0] data;
      logic                  dv;
      logic                  crs;
   } rx_seg_t;

   typedef struct packed {
      logic [SEG_DATA_W-1:0] data;
      logic                  en;
      logic                  err;
   } tx_seg_t;

   function automatic logic [SEG_DATA_W-1:0] pack_status(
      input logic err_prev,
      input logic fast,
      input logic fdx,
      input logic link,
      input logic jab,
      input logic fcar);
      logic [SEG_DATA_W-1:0] s;
      s            = '0;
      s[ST_ERR]    = err_prev;
      s[ST_SPEED]  = fast;
      s[ST_DUPLEX] = fdx;
      s[ST_LINK]   = link;
      s[ST_JAB]    = jab;
      s[ST_NIBV]   = 1'b1;
      s[ST_FCAR]   = fcar;
      s[ST_ONE]    = 1'b1;
      return s;
   endfunction

endpackage

// File: rtl/smii_rep_ctr.sv
module smii_rep_ctr #(
   parameter int REPEAT = 10,
   localparam int IDX_W = (REPEAT > 1) ? $clog2(REPEAT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [IDX_W-1:0] idx
);

   generate
      if (REPEAT > 1) begin : g_count
         localparam logic [IDX_W-1:0] LAST = IDX_W'(REPEAT - 1);
         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               idx <= '0;
            end else if (adv) begin
               idx <= (idx == LAST) ? '0 : idx + 1'b1;
            end
         end
      end else begin : g_none
         assign idx = '0;
      end
   endgenerate

endmodule

// File: rtl/smii_rx_ser.sv
module smii_rx_ser
   import smii_seg_pkg::*;
#(
   parameter int REPEAT = 10,
   localparam int IDX_W = (REPEAT > 1) ? $clog2(REPEAT) : 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    slow_i,
   input  logic    sync_i,
   input  rx_seg_t word_i,
   output logic    rxd_o
);

   logic [IDX_W-1:0] rep_idx;
   logic             load_new;
   logic [SEG_W-1:0] held_q;
   logic [SEG_W-1:0] shift_q;
   logic [SEG_W-1:0] src;

   smii_rep_ctr #(.REPEAT(REPEAT)) i_rep (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!slow_i),
      .adv   (sync_i),
      .idx   (rep_idx)
   );

   assign load_new = (rep_idx == '0);
   assign src      = load_new ? SEG_W'(word_i) : held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q  <= '0;
         shift_q <= '0;
         rxd_o   <= 1'b0;
      end else if (sync_i) begin
         if (load_new) held_q <= SEG_W'(word_i);
         rxd_o   <= src[0];
         shift_q <= src >> 1;
      end else begin
         rxd_o   <= shift_q[0];
         shift_q <= shift_q >> 1;
      end
   end

endmodule

// File: rtl/smii_tx_des.sv
module smii_tx_des
   import smii_seg_pkg::*;
#(
   parameter int REPEAT      = 10,
   parameter int CAPTURE_REP = 4,
   localparam int IDX_W = (REPEAT > 1) ? $clog2(REPEAT) : 1,
   localparam int CNT_W = $clog2(SEG_W + 1)
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    slow_i,
   input  logic    sync_i,
   input  logic    txd_i,
   output tx_seg_t seg_o,
   output logic    stb_o
);

   localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(SEG_W - 1);
   localparam logic [CNT_W-1:0] IDLE_POS = CNT_W'(SEG_W);
   localparam logic [IDX_W-1:0] TAKE_IDX = IDX_W'(CAPTURE_REP);

   logic [CNT_W-1:0] pos_q;
   logic [SEG_W-2:0] bits_q;
   logic             done;
   logic             take;
   logic [IDX_W-1:0] rep_idx;

   assign done = !sync_i && (pos_q == LAST_POS);
   assign take = done && (!slow_i || rep_idx == TAKE_IDX);

   smii_rep_ctr #(.REPEAT(REPEAT)) i_rep (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!slow_i),
      .adv   (done),
      .idx   (rep_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q  <= IDLE_POS;
         bits_q <= '0;
      end else if (sync_i) begin
         bits_q[0] <= txd_i;
         pos_q     <= CNT_W'(1);
      end else if (pos_q != IDLE_POS) begin
         for (int b = 1; b < SEG_W - 1; b++) begin
            if (pos_q == CNT_W'(b)) bits_q[b] <= txd_i;
         end
         pos_q <= pos_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_o <= '0;
         stb_o <= 1'b0;
      end else begin
         stb_o <= take;
         if (take) seg_o <= tx_seg_t'({txd_i, bits_q});
      end
   end

endmodule

// File: rtl/smii_seg_port.sv
module smii_seg_port
   import smii_seg_pkg::*;
#(
   parameter int REPEAT      = 10,
   parameter int CAPTURE_REP = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mode_10m_i,
   input  logic                  sync_i,
   input  logic                  rx_crs_i,
   input  logic                  rx_dv_i,
   input  logic [SEG_DATA_W-1:0] rx_data_i,
   input  logic                  rx_err_prev_i,
   input  logic                  link_up_i,
   input  logic                  full_duplex_i,
   input  logic                  jabber_i,
   input  logic                  false_carrier_i,
   output logic                  rxd_o,
   input  logic                  txd_i,
   output logic [SEG_DATA_W-1:0] tx_data_o,
   output logic                  tx_en_o,
   output logic                  tx_err_o,
   output logic                  tx_stb_o
);

   generate
      if (REPEAT < 1) begin : g_bad_rep
         $error("REPEAT must be at least 1");
      end
      if (CAPTURE_REP < 0 || CAPTURE_REP >= REPEAT) begin : g_bad_cap
         $error("CAPTURE_REP must lie in 0 .. REPEAT-1");
      end
   endgenerate

   rx_seg_t rx_word;
   tx_seg_t tx_seg;

   always_comb begin
      rx_word.crs  = rx_crs_i;
      rx_word.dv   = rx_dv_i;
      rx_word.data = rx_dv_i ? rx_data_i
                             : pack_status(rx_err_prev_i, !mode_10m_i, full_duplex_i,
                                           link_up_i, jabber_i, false_carrier_i);
   end

   smii_rx_ser #(.REPEAT(REPEAT)) i_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .slow_i (mode_10m_i),
      .sync_i (sync_i),
      .word_i (rx_word),
      .rxd_o  (rxd_o)
   );

   smii_tx_des #(.REPEAT(REPEAT), .CAPTURE_REP(CAPTURE_REP)) i_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .slow_i (mode_10m_i),
      .sync_i (sync_i),
      .txd_i  (txd_i),
      .seg_o  (tx_seg),
      .stb_o  (tx_stb_o)
   );

   assign tx_data_o = tx_seg.data;
   assign tx_en_o   = tx_seg.en;
   assign tx_err_o  = tx_seg.err;

endmodule

// File: rtl/smii_seg_port_chk.sv
module smii_seg_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_10m_i,
   input logic       sync_i,
   input logic       rx_crs_i,
   input logic       rxd_o,
   input logic       tx_stb_o,
   input logic [7:0] tx_data_o,
   input logic       tx_en_o,
   input logic       tx_err_o
);

   logic [3:0] since_sync;

   always_ff @(posedge clk) begin
      if (!rst_n)                 since_sync <= '0;
      else if (sync_i)            since_sync <= 4'd1;
      else if (since_sync != 4'hF) since_sync <= since_sync + 4'd1;
   end

   AST_STB_TENTH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stb_o |-> since_sync == 4'd10); // R5

   AST_CRS_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sync_i) && !$past(mode_10m_i)) |-> rxd_o == $past(rx_crs_i)); // R2

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_stb_o |-> ($stable(tx_data_o) && $stable(tx_en_o) && $stable(tx_err_o))); // R10

   AST_SLOW_NO_BACKTOBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_10m_i && tx_stb_o) |=> !tx_stb_o); // R8

endmodule

bind smii_seg_port smii_seg_port_chk i_chk (.*);

// File: tb/test_smii_seg_port.sv
module test_smii_seg_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_10m_i = 1'b0;
   logic       sync_i = 1'b0;
   logic       rx_crs_i = 1'b0;
   logic       rx_dv_i = 1'b0;
   logic [7:0] rx_data_i = '0;
   logic       rx_err_prev_i = 1'b0;
   logic       link_up_i = 1'b0;
   logic       full_duplex_i = 1'b0;
   logic       jabber_i = 1'b0;
   logic       false_carrier_i = 1'b0;
   logic       rxd_o;
   logic       txd_i = 1'b0;
   logic [7:0] tx_data_o;
   logic       tx_en_o;
   logic       tx_err_o;
   logic       tx_stb_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   smii_seg_port i_smii_seg_port (.*);

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic set_rx(input logic crs, input logic dv, input logic [7:0] d,
                         input logic ep, input logic lk, input logic fd,
                         input logic jb, input logic fc);
      rx_crs_i = crs; rx_dv_i = dv; rx_data_i = d;
      rx_err_prev_i = ep; link_up_i = lk; full_duplex_i = fd;
      jabber_i = jb; false_carrier_i = fc;
   endtask

   // called at a negedge; leaves at the negedge that starts the next segment
   task automatic run_seg(input logic [9:0] txw, output logic [9:0] rxw,
                          output logic stb, output logic [7:0] tb,
                          output logic ten, output logic terr);
      sync_i = 1'b1;
      txd_i  = txw[0];
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         if (k == 1) sync_i = 1'b0;
         rxw[k-1] = rxd_o;
         if (k < 10) txd_i = txw[k];
         else begin
            stb = tx_stb_o; tb = tx_data_o; ten = tx_en_o; terr = tx_err_o;
         end
      end
   endtask

   task automatic set_mode(input logic m);
      mode_10m_i = m;
      @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 rxd", rxd_o, 0);
      check("R1 tx_data", tx_data_o, 0);
      check("R1 tx_en", tx_en_o, 0);
      check("R1 tx_err", tx_err_o, 0);
      check("R1 tx_stb", tx_stb_o, 0);
   endtask

   task automatic t_fast_data;
      logic [9:0] r; logic s, e, er; logic [7:0] b;
      set_rx(1, 1, 8'hA5, 1, 0, 0, 1, 1);
      run_seg({8'h3C, 1'b1, 1'b0}, r, s, b, e, er);
      check("R2 crs first", r[0], 1);
      check("R2 dv second", r[1], 1);
      check("R3 data byte", r[9:2], 8'hA5);
      check("R5 strobe", s, 1);
      check("R5 tx byte", b, 8'h3C);
      check("R5 tx en", e, 1);
      check("R5 tx err", er, 0);
   endtask

   task automatic t_fast_status;
      logic [9:0] r; logic s, e, er; logic [7:0] b;
      set_rx(0, 0, 8'h00, 1, 1, 1, 0, 1);
      run_seg({8'hC3, 1'b1, 1'b1}, r, s, b, e, er);
      check("R2 crs", r[0], 0);
      check("R2 dv", r[1], 0);
      check("R4 status fast", r[9:2], 8'hEF);
      check("R6 second strobe", s, 1);
      check("R5 tx byte 2", b, 8'hC3);
      check("R5 tx err 2", er, 1);
      check("R5 tx en 2", e, 1);
   endtask

   task automatic t_resync;
      logic [9:0] r; logic s, e, er; logic [7:0] b;
      set_rx(1, 1, 8'hFF, 0, 0, 0, 0, 0);
      sync_i = 1'b1;
      txd_i  = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk);
         if (k == 1) sync_i = 1'b0;
         check("R9 no strobe on partial", tx_stb_o, 0);
         txd_i = 1'b1;
      end
      set_rx(0, 1, 8'h81, 0, 0, 0, 0, 0);
      run_seg({8'h66, 1'b1, 1'b0}, r, s, b, e, er);
      check("R9 rx restart", r, {8'h81, 1'b1, 1'b0});
      check("R9 tx strobe after resync", s, 1);
      check("R9 tx byte after resync", b, 8'h66);
      check("R9 tx err after resync", er, 0);
   endtask

   task automatic t_slow_rx;
      logic [9:0] r; logic s, e, er; logic [7:0] b;
      set_mode(1'b1);
      set_rx(1, 0, 8'h00, 0, 1, 0, 1, 0);
      run_seg(10'h0, r, s, b, e, er);
      check("R4 status slow", r[9:2], 8'hB8);
      check("R7 first copy", r, {8'hB8, 1'b0, 1'b1});
      set_rx(1, 1, 8'h5A, 1, 0, 1, 0, 1);
      for (int j = 1; j < 10; j++) begin
         run_seg(10'h0, r, s, b, e, er);
         check("R7 repeated copy", r, {8'hB8, 1'b0, 1'b1});
      end
      run_seg(10'h0, r, s, b, e, er);
      check("R7 new sample after ten", r, {8'h5A, 1'b1, 1'b1});
   endtask

   task automatic t_slow_tx;
      logic [9:0] r; logic s, e, er; logic [7:0] b;
      set_mode(1'b0);
      set_mode(1'b1);
      for (int j = 0; j < 10; j++) begin
         run_seg({8'h10 + 8'(j), 1'b1, 1'b0}, r, s, b, e, er);
         check("R8 strobe only on fifth", s, (j == 4) ? 1 : 0);
         if (j == 4) check("R8 fifth copy byte", b, 8'h14);
         if (j > 4)  check("R10 byte held", b, 8'h14);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fast_data();
      t_fast_status();
      t_resync();
      t_slow_rx();
      t_slow_tx();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule